// File: doc/BRIEF.md
# Watchdog and Processor Reset Generator

This block drives the reset line of an embedded processor. A power-on or push-button reset holds the processor in reset for one full second. A programmable watchdog can then be armed with a timeout in whole seconds, and a software-reset command pulses the processor reset on request. The block keeps a small status word that software can read. Its lower nibble counts watchdog trips and its top bit records that a software reset happened. Both survive every reset the block issues to the processor.

Time comes from an external single-cycle one-second tick. The processor reaches the block through a plain write strobe with an 8-bit data word and a continuously driven status output. Only the power-on/button input resets the block itself. The processor reset it produces goes to the processor alone and never loops back into this logic.

Top module: `wdt_reset_gen`

## Requirements
- R1: While `por_n` is low, `cpu_rst` is high. After `por_n` rises, `cpu_rst` stays high until the second `sec_tick` (PULSE_TICKS+1 ticks with the default PULSE_TICKS=1) and is low from the following cycle onward.
- R2: A write of a nonzero value N arms the watchdog. Once N ticks have arrived while `cpu_rst` is low, `cpu_rst` is high from the cycle after the Nth tick.
- R3: A nonzero write made before the timeout expires reloads the count to the written value, and that reload prevents the trip that was due.
- R4: A write of 0 drives `cpu_rst` high from the cycle after the write, for the same pulse length as in R1, counted from the write.
- R5: A write of 0 neither arms, disarms nor reloads the watchdog. The count in progress resumes after the pulse from where it stopped.
- R6: `status[3:0]` increments by one on each watchdog trip and saturates at 15.
- R7: `status[4]` is set by a write of 0 and stays set.
- R8: No write of any value clears `status`, and neither do the processor resets the block issues. Only `por_n` low returns `status` to 0.
- R9: After a trip the watchdog stays armed with the last written timeout. It reloads that timeout and does not count ticks while `cpu_rst` is high.
- R10: After `por_n` the timeout is 0, meaning disabled, and `status` is 0. No trip happens before a nonzero write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on / button reset, active low, asynchronous |
| sec_tick | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Write strobe for the watchdog register |
| wr_data | input | TO_W | Timeout in seconds; 0 requests a software reset |
| cpu_rst | output | 1 | Processor reset, active high |
| status | output | TRIP_W+1 | {software-reset flag, watchdog trip count} |

## Verification
The bench aims at the pulse length around the tick edges, since a design off by one tick would release the processor a second early. It checks that a zero write leaves the count in progress alone, because a design that reloaded or disarmed the watchdog would trip late or never. It drives enough one-second timeouts to hit the trip-count ceiling, which a design without saturation would wrap to 0. It also confirms that ticks landing during a pulse do not age the watchdog, because a design that counted them with a timeout of 1 would hold the processor in reset for good.

// File: rtl/wdt_reset_gen.sv
module wdt_reset_gen #(
  parameter int TO_W        = 8,
  parameter int TRIP_W      = 4,
  parameter int PULSE_TICKS = 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sec_tick,
  input  logic              wr_en,
  input  logic [TO_W-1:0]   wr_data,
  output logic              cpu_rst,
  output logic [TRIP_W:0]   status
);
  localparam int PC_W = $clog2(PULSE_TICKS + 2);
  localparam logic [PC_W-1:0]   PULSE_LOAD = PC_W'(PULSE_TICKS + 1);
  localparam logic [TRIP_W-1:0] TRIP_MAX   = '1;

  logic [PC_W-1:0]   pulse_cnt;
  logic [TO_W-1:0]   to_load, to_cnt;
  logic [TRIP_W-1:0] trips;
  logic              sw_flag;

  wire sw_req = wr_en && (wr_data == '0);
  wire kick   = wr_en && (wr_data != '0);
  wire armed  = (to_load != '0);
  wire count  = sec_tick && !cpu_rst && armed && !wr_en;
  wire trip   = count && (to_cnt == TO_W'(1));

  assign cpu_rst = (pulse_cnt != '0);
  assign status  = {sw_flag, trips};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pulse_cnt <= PULSE_LOAD;
      to_load   <= '0;
      to_cnt    <= '0;
      trips     <= '0;
      sw_flag   <= 1'b0;
    end else begin
      if (sw_req || trip)
        pulse_cnt <= PULSE_LOAD;
      else if (sec_tick && cpu_rst)
        pulse_cnt <= pulse_cnt - 1'b1;
      if (sw_req)
        sw_flag <= 1'b1;
      if (kick) begin
        to_load <= wr_data;
        to_cnt  <= wr_data;
      end else if (trip) begin
        to_cnt <= to_load;
        if (trips != TRIP_MAX) trips <= trips + 1'b1;
      end else if (count) begin
        to_cnt <= to_cnt - 1'b1;
      end
    end
  end

  assert_release_on_tick_R1: assert property (@(posedge clk) disable iff (!por_n)
    $fell(cpu_rst) |-> $past(sec_tick));
  assert_kick_no_rst_R3: assert property (@(posedge clk) disable iff (!por_n)
    (kick && !cpu_rst) |=> !cpu_rst);
  assert_sw_reset_R4: assert property (@(posedge clk) disable iff (!por_n)
    sw_req |=> (cpu_rst && pulse_cnt == PULSE_LOAD));
  assert_sw_keeps_wd_R5: assert property (@(posedge clk) disable iff (!por_n)
    sw_req |=> ($stable(to_load) && $stable(to_cnt)));
  assert_trips_monotone_R6: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> (trips >= $past(trips)));
  assert_sw_flag_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
    sw_flag |=> sw_flag);
  assert_no_count_in_rst_R9: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_rst && !wr_en) |=> $stable(to_cnt) || (to_cnt == to_load));
endmodule

// File: tb/test_wdt_reset_gen.sv
module test_wdt_reset_gen;
  logic clk = 1'b0;
  logic por_n = 1'b0, sec_tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic cpu_rst;
  logic [4:0] status;

  int n_tests = 0, n_fail = 0;
  int m_pc, m_ld, m_cnt, m_trips;
  bit m_sw;
  string cur_tag = "R10";

  wdt_reset_gen i_wdt_reset_gen (.clk(clk), .por_n(por_n), .sec_tick(sec_tick),
    .wr_en(wr_en), .wr_data(wr_data), .cpu_rst(cpu_rst), .status(status));

  always #5 clk = ~clk;

  function automatic int exp_status();
    return (m_sw ? 16 : 0) + m_trips;
  endfunction

  task automatic model_step();
    int pc0 = m_pc;
    if (!por_n) begin
      m_pc = 2; m_ld = 0; m_cnt = 0; m_trips = 0; m_sw = 0;
      return;
    end
    if (sec_tick && pc0 != 0) m_pc = pc0 - 1;
    if (wr_en && wr_data == 0) begin
      m_pc = 2; m_sw = 1;
    end else if (wr_en) begin
      m_ld = wr_data; m_cnt = wr_data;
    end else if (sec_tick && pc0 == 0 && m_ld != 0) begin
      if (m_cnt == 1) begin
        m_pc = 2; m_cnt = m_ld;
        if (m_trips < 15) m_trips++;
      end else m_cnt--;
    end
  endtask

  task automatic chk(string tag, int got_rst, int exp_rst, int got_st, int exp_st);
    n_tests++;
    if (got_rst != exp_rst || got_st != exp_st) begin
      n_fail++;
      $display("FAIL %s: rst=%0d status=%0h, expected rst=%0d status=%0h",
               tag, got_rst, got_st, exp_rst, exp_st);
    end
  endtask

  task automatic step(bit tk, bit we, int d);
    sec_tick = tk; wr_en = we; wr_data = 8'(d);
    @(posedge clk);
    model_step();
    @(negedge clk);
    sec_tick = 0; wr_en = 0;
    chk(cur_tag, cpu_rst, (m_pc != 0), status, exp_status());
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < 4; g++) step(0, 0, 0);
      step(1, 0, 0);
    end
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 0;
    step(0, 0, 0); step(0, 0, 0);
    por_n = 1;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run hung");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    m_pc = 2; m_ld = 0; m_cnt = 0; m_trips = 0; m_sw = 0;
    do_por();
    chk("R10 reset state", cpu_rst, 1, status, 0);
    cur_tag = "R1";
    ticks(1); chk("R1 still held after 1st tick", cpu_rst, 1, status, 0);
    ticks(1); chk("R1 released after 2nd tick", cpu_rst, 0, status, 0);
    cur_tag = "R10";
    ticks(6); chk("R10 disabled by default", cpu_rst, 0, status, 0);
    cur_tag = "R2";
    step(0, 1, 3);
    ticks(2); chk("R2 no trip before timeout", cpu_rst, 0, status, 0);
    ticks(1); chk("R2 trip at 3rd tick", cpu_rst, 1, status, 1);
    cur_tag = "R9";
    ticks(2); chk("R9 pulse over", cpu_rst, 0, status, 1);
    ticks(3); chk("R9 rearmed trip", cpu_rst, 1, status, 2);
    ticks(2);
    cur_tag = "R3";
    ticks(2); step(0, 1, 3); ticks(2);
    chk("R3 reload averts trip", cpu_rst, 0, status, 2);
    ticks(1); chk("R3 trip after reload", cpu_rst, 1, status, 3);
    ticks(2);
    cur_tag = "R4";
    ticks(1); step(0, 1, 0);
    chk("R4 software reset", cpu_rst, 1, status, 8'h13);
    ticks(1); chk("R4 held one tick", cpu_rst, 1, status, 8'h13);
    ticks(1); chk("R4 released", cpu_rst, 0, status, 8'h13);
    cur_tag = "R5";
    ticks(1); chk("R5 count resumes", cpu_rst, 0, status, 8'h13);
    ticks(1); chk("R5 trip w/o reload", cpu_rst, 1, status, 8'h14);
    ticks(2);
    cur_tag = "R6";
    step(0, 1, 1);
    ticks(45); chk("R6 saturates at 15", status[3:0], 15, status, 8'h1f);
    cur_tag = "R8";
    step(0, 1, 8'hff); step(0, 1, 0); ticks(3);
    chk("R8 writes keep status", status[4], 1, status, 8'h1f);
    cur_tag = "R7";
    chk("R7 flag sticky", status[4], 1, status[4], 1);
    cur_tag = "R8";
    do_por();
    chk("R8 por clears status", cpu_rst, 1, status, 0);
    ticks(2);
    cur_tag = "R10";
    ticks(10); chk("R10 no trip after por", cpu_rst, 0, status, 0);
    cur_tag = "R9 random";
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 2) do_por();
      else if (r < 6) step($urandom_range(0, 3) == 0, 1, $urandom_range(0, 4));
      else if (r < 8) step(0, 1, $urandom_range(0, 255));
      else step($urandom_range(0, 3) == 0, 0, 0);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule